// File: doc/BRIEF.md
# Multi-Mode Test Response Compactor

This block takes a serial stream of single-bit responses from a circuit under test and reduces it to three compact figures at once. It counts the transitions between successive accepted bits, counts the ones, and folds every accepted bit into a serial-input LFSR signature. A start pulse clears all three figures and latches the length of the capture window. Each response bit is accepted only in a cycle where the valid strobe is high.

Once the programmed number of bits has been accepted, the window closes. A one-cycle done pulse follows. The three figures then stay frozen until the next start. Each figure is compared with its own expected-value input, and the result appears on a separate pass bit, so a test controller can tell which compaction method caught a fault.

A typical use is an exhaustive test of a 2:1 multiplexer. Its eight input combinations give an eight-bit window. The expected figures are precomputed from a good circuit.

The control path is a four-state machine:
- **IDLE** is the state after reset.
- **CAPTURE** accepts valid bits.
- **FINISH** is the single done cycle.
- **HOLD** keeps the closed-window results.

The transitions are:
- *start* moves any state to CAPTURE, or to FINISH when the window length is zero.
- *last-bit* moves CAPTURE to FINISH when the accepted bit completes the window.
- *settle* moves FINISH to HOLD unconditionally.

Top module: `resp_compactor`

## Requirements
- R1: After reset the block is in IDLE. The transition count, ones count and signature are all zero, and done and all pass bits are 0.
- R2: A start pulse clears all three figures to zero, latches `win_len` and opens a new window. This applies in any state, including in the middle of a window. A valid bit presented in the same cycle as start is discarded.
- R3: The transition count increases by one for each accepted bit that differs from the previously accepted bit of the same window. The first accepted bit after start never counts.
- R4: The ones count increases by one for each accepted bit equal to 1.
- R5: The signature register s (bit 3 is the MSB) updates on each accepted bit b as s <= {s[2:0], s[3]^s[2]^b}, which implements x^4+x^3+1 with the response XORed into the feedback.
- R6: The window closes on the clock edge that accepts the `win_len`-th valid bit. Cycles with the strobe low are skipped and do not count toward the window. With `win_len` = 0, the window closes on the start edge itself.
- R7: `done` is high for exactly the one cycle after the edge that closes the window, and is low otherwise.
- R8: While the window is closed and no start arrives, the three figures stay constant and valid strobes are ignored. The same holds in IDLE before the first start.
- R9: Each pass bit is 1 exactly when the window is closed and its figure equals the matching expected input. While in IDLE or CAPTURE every pass bit is 0.
- R10: The counters are wide enough not to wrap at the maximum window of 15 bits. An alternating 15-bit window gives a transition count of 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the figures and opens a window |
| win_len | input | 4 | Number of valid bits in the window, latched at start |
| resp_vld | input | 1 | Response bit is valid this cycle |
| resp_bit | input | 1 | Response bit from the circuit under test |
| exp_trans | input | 4 | Expected transition count |
| exp_ones | input | 4 | Expected ones count |
| exp_sig | input | 4 | Expected signature |
| done | output | 1 | One-cycle pulse after the window closes |
| trans_cnt | output | 4 | Transition count |
| ones_cnt | output | 4 | Ones count |
| signature | output | 4 | LFSR signature |
| pass_trans | output | 1 | Transition count matches its expected value |
| pass_ones | output | 1 | Ones count matches its expected value |
| pass_sig | output | 1 | Signature matches its expected value |

## Verification
A wrong state or window counter shows up as a `done` pulse one or more cycles early or late. The bench samples at the exact cycle that R7 predicts, so such an error appears within a single window. A corrupted previous-bit or first-bit flag changes the transition count, and a wrong feedback tap changes the signature; both are visible at the first `done` after the fault. A leak of valid strobes into HOLD or IDLE changes a frozen figure within one cycle. The bench reads the figures after such strobes and before the next start.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FINISH  = 2'd2,
        ST_HOLD    = 2'd3
    } cmp_state_e;

endpackage

// File: rtl/resp_cmp_ctrl.sv
module resp_cmp_ctrl
    import resp_cmp_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resp_vld,
    input  logic [LEN_W-1:0] win_len,
    output logic             take,
    output logic             closed,
    output logic             done,
    output logic [LEN_W-1:0] bit_cnt
);

    cmp_state_e       state_q, state_d;
    logic [LEN_W-1:0] win_q;
    logic             last_bit;

    assign take     = (state_q == ST_CAPTURE) && resp_vld && !start;
    assign last_bit = take && (({1'b0, bit_cnt} + 1'b1) == {1'b0, win_q});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (win_len == '0) ? ST_FINISH : ST_CAPTURE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_CAPTURE: state_d = last_bit ? ST_FINISH : ST_CAPTURE;
                ST_FINISH:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = 1'b0;
        closed = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CAPTURE: ;
            ST_FINISH: begin
                done   = 1'b1;
                closed = 1'b1;
            end
            ST_HOLD:    closed = 1'b1;
            default:    ;
        endcase
    end

    // window length latch and accepted-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            bit_cnt <= '0;
        end else if (start) begin
            win_q   <= win_len;
            bit_cnt <= '0;
        end else if (take) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_closed_ignores_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !start) |=> $stable(bit_cnt));

    assert_done_at_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bit_cnt == win_q));

endmodule

// File: rtl/resp_cmp_counts.sv
module resp_cmp_counts #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic             bit_i,
    output logic [CNT_W-1:0] trans_cnt,
    output logic [CNT_W-1:0] ones_cnt
);

    logic prev_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            seen_q    <= 1'b0;
            trans_cnt <= '0;
            ones_cnt  <= '0;
        end else if (clr) begin
            prev_q    <= 1'b0;
            seen_q    <= 1'b0;
            trans_cnt <= '0;
            ones_cnt  <= '0;
        end else if (take) begin
            prev_q <= bit_i;
            seen_q <= 1'b1;
            if (seen_q && (bit_i != prev_q)) trans_cnt <= trans_cnt + 1'b1;
            if (bit_i)                       ones_cnt  <= ones_cnt + 1'b1;
        end
    end

    assert_ones_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (ones_cnt >= $past(ones_cnt)));

    assert_first_bit_no_transition_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr && !seen_q) |=> (trans_cnt == '0));

endmodule

// File: rtl/resp_cmp_sig.sv
module resp_cmp_sig #(
    parameter int              SIG_W = 4,
    parameter logic [SIG_W-1:0] TAPS = 4'b1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic             bit_i,
    output logic [SIG_W-1:0] sig
);

    logic [SIG_W-1:0] tapped;
    logic             fb;

    genvar g;
    generate
        for (g = 0; g < SIG_W; g++) begin : g_tap
            if (TAPS[g]) begin : g_on
                assign tapped[g] = sig[g];
            end else begin : g_off
                assign tapped[g] = 1'b0;
            end
        end
    endgenerate

    assign fb = (^tapped) ^ bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sig <= '0;
        else if (clr)    sig <= '0;
        else if (take)   sig <= {sig[SIG_W-2:0], fb};
    end

    assert_sig_shifts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (sig[SIG_W-1:1] == $past(sig[SIG_W-2:0])));

endmodule

// File: rtl/resp_compactor.sv
module resp_compactor #(
    parameter int              MAX_WIN = 15,
    parameter int              SIG_W   = 4,
    parameter logic [SIG_W-1:0] TAPS   = 4'b1100,
    localparam int             LEN_W   = $clog2(MAX_WIN + 1),
    localparam int             CNT_W   = LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] win_len,
    input  logic             resp_vld,
    input  logic             resp_bit,
    input  logic [CNT_W-1:0] exp_trans,
    input  logic [CNT_W-1:0] exp_ones,
    input  logic [SIG_W-1:0] exp_sig,
    output logic             done,
    output logic [CNT_W-1:0] trans_cnt,
    output logic [CNT_W-1:0] ones_cnt,
    output logic [SIG_W-1:0] signature,
    output logic             pass_trans,
    output logic             pass_ones,
    output logic             pass_sig
);

    logic             take;
    logic             closed;
    logic [LEN_W-1:0] bit_cnt;

    resp_cmp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .resp_vld (resp_vld),
        .win_len  (win_len),
        .take     (take),
        .closed   (closed),
        .done     (done),
        .bit_cnt  (bit_cnt)
    );

    resp_cmp_counts #(.CNT_W(CNT_W)) u_counts (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .take      (take),
        .bit_i     (resp_bit),
        .trans_cnt (trans_cnt),
        .ones_cnt  (ones_cnt)
    );

    resp_cmp_sig #(.SIG_W(SIG_W), .TAPS(TAPS)) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .take  (take),
        .bit_i (resp_bit),
        .sig   (signature)
    );

    always_comb begin
        pass_trans = closed && (trans_cnt == exp_trans);
        pass_ones  = closed && (ones_cnt  == exp_ones);
        pass_sig   = closed && (signature == exp_sig);
    end

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (trans_cnt == '0 && ones_cnt == '0 && signature == '0));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !start) |=> ($stable(trans_cnt) && $stable(ones_cnt) && $stable(signature)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_cnt <= bit_cnt) && (trans_cnt == '0 || trans_cnt < bit_cnt));

    assert_pass_only_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_trans || pass_ones || pass_sig) |-> (done || $past(closed)));

endmodule

// File: tb/resp_compactor_tb.sv
module resp_compactor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] win_len = '0;
    logic       resp_vld = 1'b0;
    logic       resp_bit = 1'b0;
    logic [3:0] exp_trans = '0;
    logic [3:0] exp_ones = '0;
    logic [3:0] exp_sig = '0;
    logic       done;
    logic [3:0] trans_cnt, ones_cnt, signature;
    logic       pass_trans, pass_ones, pass_sig;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int t;
        int o;
        int s;
        int pt;
        int po;
        int ps;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    resp_compactor u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
        .resp_vld(resp_vld), .resp_bit(resp_bit),
        .exp_trans(exp_trans), .exp_ones(exp_ones), .exp_sig(exp_sig),
        .done(done), .trans_cnt(trans_cnt), .ones_cnt(ones_cnt), .signature(signature),
        .pass_trans(pass_trans), .pass_ones(pass_ones), .pass_sig(pass_sig)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk("R7 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk("R3 trans_cnt", int'(trans_cnt), it.t);
                chk("R4 ones_cnt", int'(ones_cnt), it.o);
                chk("R5 signature", int'(signature), it.s);
                chk("R9 pass_trans", int'(pass_trans), it.pt);
                chk("R9 pass_ones", int'(pass_ones), it.po);
                chk("R9 pass_sig", int'(pass_sig), it.ps);
            end
        end
    end

    // driver: wrong selects which expected input is made wrong (0 none, 1 trans, 2 ones, 3 sig)
    task automatic run_window(input logic [14:0] bits, input int len, input int wrong,
                              input bit gaps, input bit vld_on_start);
        int t = 0;
        int o = 0;
        logic [3:0] s = '0;
        item_t it;
        for (int i = 0; i < len; i++) begin
            if (i > 0 && bits[i] != bits[i-1]) t++;
            if (bits[i]) o++;
            s = {s[2:0], s[3] ^ s[2] ^ bits[i]};
        end
        exp_trans = 4'(t + (wrong == 1 ? 1 : 0));
        exp_ones  = 4'(o + (wrong == 2 ? 1 : 0));
        exp_sig   = s ^ ((wrong == 3) ? 4'h1 : 4'h0);
        it.t = t; it.o = o; it.s = int'(s);
        it.pt = (wrong != 1); it.po = (wrong != 2); it.ps = (wrong != 3);
        sb_q.push_back(it);

        @(posedge clk); #1;
        start = 1'b1; win_len = 4'(len); resp_vld = vld_on_start; resp_bit = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            start = 1'b0;
            if (gaps) begin
                resp_vld = 1'b0; resp_bit = ~bits[i];
                @(posedge clk); #1;
            end
            resp_vld = 1'b1; resp_bit = bits[i];
        end
        @(posedge clk); #1;
        start = 1'b0; resp_vld = 1'b0;
        @(negedge clk);
        chk("R7 done after last bit (R6)", int'(done), 1);
        @(negedge clk);
        chk("R7 done falls", int'(done), 0);
    endtask

    // closed or idle: strobes must not change anything
    task automatic strobe_ignored(input string req);
        logic [3:0] t0, o0, s0;
        @(negedge clk);
        t0 = trans_cnt; o0 = ones_cnt; s0 = signature;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            resp_vld = 1'b1; resp_bit = i[0];
        end
        @(posedge clk); #1;
        resp_vld = 1'b0;
        @(negedge clk);
        chk({req, " trans held"}, int'(trans_cnt), int'(t0));
        chk({req, " ones held"}, int'(ones_cnt), int'(o0));
        chk({req, " sig held"}, int'(signature), int'(s0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1, 0);
        report();
    end

    initial begin
        logic [14:0] mux_bits;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 trans", int'(trans_cnt), 0);
        chk("R1 ones", int'(ones_cnt), 0);
        chk("R1 sig", int'(signature), 0);
        chk("R1 done", int'(done), 0);
        chk("R9 pass idle", int'({pass_trans, pass_ones, pass_sig}), 0);

        // R8 strobes in IDLE ignored
        strobe_ignored("R8 idle");

        // exhaustive 2:1 mux responses: sel=v[2], b=v[1], a=v[0]
        mux_bits = '0;
        for (int v = 0; v < 8; v++) mux_bits[v] = v[2] ? v[1] : v[0];
        run_window(mux_bits, 8, 0, 1'b0, 1'b0);

        // R8 strobes while closed ignored
        strobe_ignored("R8 hold");

        // expected value mismatches, one per figure (R9)
        run_window(mux_bits, 8, 1, 1'b0, 1'b0);
        run_window(mux_bits, 8, 2, 1'b0, 1'b0);
        run_window(mux_bits, 8, 3, 1'b0, 1'b0);

        // gaps in the strobe (R6)
        run_window(15'b000_0000_1101_1010, 8, 0, 1'b1, 1'b0);

        // restart mid-window with a strobe in the start cycle (R2)
        @(posedge clk); #1;
        start = 1'b1; win_len = 4'd8;
        @(posedge clk); #1;
        start = 1'b0; resp_vld = 1'b1; resp_bit = 1'b1;
        repeat (3) @(posedge clk);
        #1 resp_vld = 1'b0;
        @(negedge clk);
        chk("R9 pass low in capture", int'({pass_trans, pass_ones, pass_sig}), 0);
        run_window(15'b000_0000_0000_0110, 4, 0, 1'b0, 1'b1);

        // single bit: no transition on first bit (R3)
        run_window(15'b1, 1, 0, 1'b0, 1'b0);
        // zero-length window (R6)
        run_window(15'b0, 0, 0, 1'b0, 1'b0);
        // maximum alternating window (R10)
        run_window(15'b101_0101_0101_0101, 15, 0, 1'b0, 1'b0);
        // all ones max window
        run_window(15'h7FFF, 15, 0, 1'b1, 1'b0);

        chk("scoreboard drained", sb_q.size(), 0);
        repeat (2) @(posedge clk);
        report();
    end

endmodule